// File: doc/BRIEF.md
# Slew-Rate Calibration Sequencer

This block runs the high-speed transmitter slew-rate calibration that follows a port power-up, without any software polling. One start pulse begins the sequence. The block switches on a ring oscillator and lets it settle. It then enables a free-running clock, programs the external frequency meter with a 1024-cycle measurement window and turns the meter on. The meter's valid flag is sampled at fixed intervals, and a sampling budget bounds how long the block waits for it.

Once the count is taken, the block shuts down the meter and then the free-running clock. It turns the count into a 3-bit slew code, writes that code, pulses a done flag, and only then switches the oscillator off. The code is `round((ref_mhz * coef * 1024 / count) / 1000)`, where the inner division truncates. A zero count gives the default code 3. A nonzero forced value skips the measurement entirely and drives the code directly. Both divisions share one sequential restoring divider.

Top module: `slew_cal_seq`

## Requirements
- R1: After reset, the oscillator, free-run clock and meter enables are 0, the window output is 0, the slew code is 0 and done is 0.
- R2: A start with a nonzero `force_code_i` sets the slew code to `force_code_i[2:0]` and pulses done once. The oscillator, free-run clock and meter stay off.
- R3: A calibration raises the oscillator enable first. The free-run clock follows at least SETTLE_CYC cycles later. The window output then reads 1024, and only after that does the meter enable rise. The meter is never on without the clock, and the clock is never on without the oscillator.
- R4: The meter valid flag is sampled once every POLL_INTERVAL cycles while the meter is on. The count is captured at the first sample that sees valid.
- R5: If valid has not been seen after POLL_TRIES samples, the sequence continues using the count present at that time.
- R6: The meter enable falls before the free-run clock enable. The oscillator enable falls only after the done pulse.
- R7: For a nonzero count, the code is the low three bits of `(floor(ref*coef*1024/count) + 500) / 1000`. `ref_mhz_i` and `coef_i` are sampled at start.
- R8: A captured count of zero gives code 3.
- R9: Only the low three bits of a computed or forced value reach the slew code (for example, 9 gives 1 and 8 gives 0).
- R10: Done is high for exactly one cycle per accepted start. The slew code holds its new value in that same cycle.
- R11: A start pulse that arrives while a calibration is in progress is ignored.
- R12: Non-default reference and coefficient inputs change the computed code according to R7. The nominal values are 26 and 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to calibrate |
| ref_mhz_i | input | REF_W | Reference frequency in MHz |
| coef_i | input | COEF_W | Slew-rate coefficient |
| force_code_i | input | FORCE_W | Nonzero value bypasses calibration |
| fm_count_i | input | CNT_W | Frequency meter result |
| fm_valid_i | input | 1 | Frequency meter result valid |
| osc_en_o | output | 1 | Ring oscillator enable |
| frck_en_o | output | 1 | Free-run clock enable |
| fm_en_o | output | 1 | Frequency meter enable |
| fm_window_o | output | CNT_W | Programmed meter window length |
| slew_code_o | output | 3 | Slew-rate control code |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with SETTLE_CYC=4, POLL_INTERVAL=8 and POLL_TRIES=5 in place of the microsecond-scale defaults. With these values the whole poll budget is 40 cycles, so a run where valid never arrives finishes quickly. The measured meter-on time can then be compared against the exact timeout, and a late valid can be placed between two specific samples. The meter model lets each test choose the count and the valid delay, which reaches the exact rounding boundary (quotients 2500 and 2486), a zero count, a result above seven, and a forced value whose low bits are zero.

// File: rtl/slew_cal_pkg.sv
package slew_cal_pkg;

    localparam int unsigned MEAS_WINDOW  = 1024;
    localparam int unsigned ROUND_DIV    = 1000;
    localparam int unsigned FALLBACK     = 3;
    localparam int unsigned NOM_REF_MHZ  = 26;
    localparam int unsigned NOM_COEF     = 17;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_WIN,
        ST_MEAS,
        ST_POLL,
        ST_MOFF,
        ST_COFF,
        ST_D1GO,
        ST_D1WAIT,
        ST_D2GO,
        ST_D2WAIT,
        ST_WRITE,
        ST_OSCOFF
    } cal_state_e;

    function automatic logic [2:0] low3(input logic [31:0] v);
        return v[2:0];
    endfunction

endpackage

// File: rtl/slew_cal_timer.sv
module slew_cal_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [CW-1:0] val_i,
    output logic          tick_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign tick_o = (cnt_q == CW'(1));

    AST_TICK_ENDS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (tick_o && !load_i) |=> !tick_o);  // R3
endmodule

// File: rtl/slew_cal_div.sv
module slew_cal_div #(
    parameter int unsigned DW = 28
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [DW-1:0] dividend_i,
    input  logic [DW-1:0] divisor_i,
    output logic [DW-1:0] quot_o,
    output logic          done_o
);
    localparam int unsigned SW = $clog2(DW + 1);

    logic [DW-1:0] quo_q, rem_q, dsr_q, dvd_q;
    logic [SW-1:0] step_q;
    logic [DW:0]   shl;
    logic          take;

    assign shl  = {rem_q, quo_q[DW-1]};
    assign take = (shl >= {1'b0, dsr_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            quo_q  <= '0;
            rem_q  <= '0;
            dsr_q  <= '0;
            dvd_q  <= '0;
            step_q <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                quo_q  <= dividend_i;
                dvd_q  <= dividend_i;
                dsr_q  <= divisor_i;
                rem_q  <= '0;
                step_q <= SW'(DW);
            end else if (step_q != '0) begin
                rem_q  <= take ? DW'(shl - {1'b0, dsr_q}) : shl[DW-1:0];
                quo_q  <= {quo_q[DW-2:0], take};
                step_q <= step_q - 1'b1;
                if (step_q == SW'(1))
                    done_o <= 1'b1;
            end
        end
    end

    assign quot_o = quo_q;

    AST_DIV_EXACT: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (({{DW{1'b0}}, quo_q} * {{DW{1'b0}}, dsr_q}) + {{DW{1'b0}}, rem_q})
                   == {{DW{1'b0}}, dvd_q});  // R7
    AST_DIV_REM_BELOW: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (rem_q < dsr_q));  // R7
endmodule

// File: rtl/slew_cal_seq.sv
module slew_cal_seq
    import slew_cal_pkg::*;
#(
    parameter int unsigned REF_W         = 8,
    parameter int unsigned COEF_W        = 8,
    parameter int unsigned FORCE_W       = 8,
    parameter int unsigned CNT_W         = 24,
    parameter int unsigned SETTLE_CYC    = 50,
    parameter int unsigned POLL_INTERVAL = 500,
    parameter int unsigned POLL_TRIES    = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [REF_W-1:0]   ref_mhz_i,
    input  logic [COEF_W-1:0]  coef_i,
    input  logic [FORCE_W-1:0] force_code_i,
    input  logic [CNT_W-1:0]   fm_count_i,
    input  logic               fm_valid_i,
    output logic               osc_en_o,
    output logic               frck_en_o,
    output logic               fm_en_o,
    output logic [CNT_W-1:0]   fm_window_o,
    output logic [2:0]         slew_code_o,
    output logic               done_o
);
    localparam int unsigned WIN_W  = $clog2(MEAS_WINDOW) + 1;
    localparam int unsigned DW     = REF_W + COEF_W + WIN_W + 1;
    localparam int unsigned TMAX   = (SETTLE_CYC > POLL_INTERVAL) ? SETTLE_CYC : POLL_INTERVAL;
    localparam int unsigned TW     = $clog2(TMAX + 1);
    localparam int unsigned PW     = $clog2(POLL_TRIES + 1);

    cal_state_e         state_q;
    logic [REF_W-1:0]   ref_q;
    logic [COEF_W-1:0]  coef_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [PW-1:0]      tries_q;
    logic [2:0]         res_q;
    logic               tmr_load, tmr_tick;
    logic [TW-1:0]      tmr_val;
    logic               poll_end;
    logic               div_start, div_done;
    logic [DW-1:0]      div_num, div_den, div_q;
    logic [DW-4:0]      div_q_hi_unused;

    assign poll_end = tmr_tick && (fm_valid_i || (tries_q == PW'(POLL_TRIES - 1)));

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = TW'(POLL_INTERVAL);
        if (state_q == ST_IDLE && start_i && force_code_i == '0) begin
            tmr_load = 1'b1;
            tmr_val  = TW'(SETTLE_CYC);
        end else if (state_q == ST_MEAS || (state_q == ST_POLL && tmr_tick && !poll_end)) begin
            tmr_load = 1'b1;
        end
    end

    always_comb begin
        div_start = (state_q == ST_D1GO) || (state_q == ST_D2GO);
        if (state_q == ST_D2GO) begin
            div_num = div_q + DW'(ROUND_DIV / 2);
            div_den = DW'(ROUND_DIV);
        end else begin
            div_num = DW'(ref_q) * DW'(coef_q) * DW'(MEAS_WINDOW);
            div_den = DW'(cnt_q);
        end
    end

    assign div_q_hi_unused = div_q[DW-1:3];

    slew_cal_timer #(.CW(TW)) u_timer (
        .clk(clk), .rst(rst), .load_i(tmr_load), .val_i(tmr_val), .tick_o(tmr_tick)
    );

    slew_cal_div #(.DW(DW)) u_div (
        .clk(clk), .rst(rst), .start_i(div_start), .dividend_i(div_num),
        .divisor_i(div_den), .quot_o(div_q), .done_o(div_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            ref_q       <= '0;
            coef_q      <= '0;
            cnt_q       <= '0;
            tries_q     <= '0;
            res_q       <= '0;
            osc_en_o    <= 1'b0;
            frck_en_o   <= 1'b0;
            fm_en_o     <= 1'b0;
            fm_window_o <= '0;
            slew_code_o <= '0;
            done_o      <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    if (force_code_i != '0) begin
                        slew_code_o <= low3(32'(force_code_i));
                        done_o      <= 1'b1;
                    end else begin
                        ref_q    <= ref_mhz_i;
                        coef_q   <= coef_i;
                        osc_en_o <= 1'b1;
                        state_q  <= ST_SETTLE;
                    end
                end
                ST_SETTLE: if (tmr_tick) begin
                    frck_en_o <= 1'b1;
                    state_q   <= ST_WIN;
                end
                ST_WIN: begin
                    fm_window_o <= CNT_W'(MEAS_WINDOW);
                    state_q     <= ST_MEAS;
                end
                ST_MEAS: begin
                    fm_en_o <= 1'b1;
                    tries_q <= '0;
                    state_q <= ST_POLL;
                end
                ST_POLL: if (tmr_tick) begin
                    if (poll_end) begin
                        cnt_q   <= fm_count_i;
                        state_q <= ST_MOFF;
                    end else begin
                        tries_q <= tries_q + 1'b1;
                    end
                end
                ST_MOFF: begin
                    fm_en_o     <= 1'b0;
                    fm_window_o <= '0;
                    state_q     <= ST_COFF;
                end
                ST_COFF: begin
                    frck_en_o <= 1'b0;
                    if (cnt_q == '0) begin
                        res_q   <= 3'(FALLBACK);
                        state_q <= ST_WRITE;
                    end else begin
                        state_q <= ST_D1GO;
                    end
                end
                ST_D1GO:   state_q <= ST_D1WAIT;
                ST_D1WAIT: if (div_done) state_q <= ST_D2GO;
                ST_D2GO:   state_q <= ST_D2WAIT;
                ST_D2WAIT: if (div_done) begin
                    res_q   <= div_q[2:0];
                    state_q <= ST_WRITE;
                end
                ST_WRITE: begin
                    slew_code_o <= res_q;
                    done_o      <= 1'b1;
                    state_q     <= ST_OSCOFF;
                end
                ST_OSCOFF: begin
                    osc_en_o <= 1'b0;
                    state_q  <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);  // R10
    AST_METER_NEEDS_CLK: assert property (@(posedge clk) disable iff (rst)
        fm_en_o |-> frck_en_o);  // R3
    AST_CLK_NEEDS_OSC: assert property (@(posedge clk) disable iff (rst)
        frck_en_o |-> osc_en_o);  // R3
    AST_OSC_HOLDS_TO_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(osc_en_o) |-> $past(done_o));  // R6
    AST_OVERRIDE_SKIPS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && start_i && force_code_i != '0) |=> (done_o && !osc_en_o));  // R2
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && state_q != ST_OSCOFF && start_i) |=> state_q != ST_IDLE);  // R11
endmodule

// File: tb/sim_slew_cal_seq.sv
`timescale 1ns/1ps
module sim_slew_cal_seq;
    localparam int SET_C = 4, POLL_I = 8, POLL_T = 5;

    logic        clk = 1'b0, rst = 1'b1, start = 1'b0, fm_valid = 1'b0;
    logic [7:0]  ref_mhz = 8'd26, coef = 8'd17, force_code = 8'd0;
    logic [23:0] fm_count = '0;
    logic        osc_en, frck_en, fm_en, done;
    logic [23:0] fm_window;
    logic [2:0]  code;

    int errors = 0, checks = 0, vdelay = -1, mcyc = 0;
    int t = 0, osc_r = -1, osc_f = -1, frck_r = -1, frck_f = -1, fm_r = -1, fm_f = -1;
    int win_t = -1, done_t = -1, done_tot = 0, fm_hi = 0;
    logic [2:0] code_at_done = '0;
    logic p_osc = 0, p_frck = 0, p_fm = 0, p_win = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    slew_cal_seq #(.SETTLE_CYC(SET_C), .POLL_INTERVAL(POLL_I), .POLL_TRIES(POLL_T)) u0 (
        .clk(clk), .rst(rst), .start_i(start), .ref_mhz_i(ref_mhz), .coef_i(coef),
        .force_code_i(force_code), .fm_count_i(fm_count), .fm_valid_i(fm_valid),
        .osc_en_o(osc_en), .frck_en_o(frck_en), .fm_en_o(fm_en), .fm_window_o(fm_window),
        .slew_code_o(code), .done_o(done)
    );

    // meter model
    always @(posedge clk) begin
        if (!fm_en) begin
            fm_valid <= 1'b0;
            mcyc     <= 0;
        end else begin
            mcyc <= mcyc + 1;
            if (mcyc == vdelay) fm_valid <= 1'b1;
        end
    end

    // event monitor
    always @(negedge clk) begin
        t = t + 1;
        if (osc_en && !p_osc) osc_r = t;
        if (!osc_en && p_osc) osc_f = t;
        if (frck_en && !p_frck) frck_r = t;
        if (!frck_en && p_frck) frck_f = t;
        if (fm_en && !p_fm) fm_r = t;
        if (!fm_en && p_fm) fm_f = t;
        if (fm_window == 24'd1024 && !p_win) win_t = t;
        if (fm_en) fm_hi = fm_hi + 1;
        if (done) begin done_t = t; done_tot = done_tot + 1; code_at_done = code; end
        p_osc = osc_en; p_frck = frck_en; p_fm = fm_en; p_win = (fm_window == 24'd1024);
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_code(input int r, input int c, input int n);
        int q;
        if (n == 0) return 3;
        q = (r * c * 1024) / n;
        return ((q + 500) / 1000) % 8;
    endfunction

    int t0, d0, h0;

    task automatic run(input int r, input int c, input int f, input int n, input int vd);
        ref_mhz = 8'(r); coef = 8'(c); force_code = 8'(f); fm_count = 24'(n); vdelay = vd;
        t0 = t; d0 = done_tot; h0 = fm_hi;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (done_tot > d0 && !osc_en) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
        chk(done_tot > d0 && !osc_en, "R10 completion", done_tot - d0, 1);
    endtask

    task automatic t_reset;
        chk(!osc_en && !frck_en && !fm_en, "R1 enables", {osc_en, frck_en, fm_en}, 0);
        chk(fm_window == 0 && code == 0 && !done, "R1 window/code/done", int'(code), 0);
    endtask

    task automatic t_basic;
        run(26, 17, 0, 150, 3);
        chk(code == 3'(exp_code(26, 17, 150)), "R7 count150", code, exp_code(26, 17, 150));
        chk(code_at_done == code, "R10 code with done", code_at_done, code);
        chk(done_tot - d0 == 1, "R10 single pulse", done_tot - d0, 1);
        chk(osc_r > t0 && frck_r - osc_r >= SET_C, "R3 settle", frck_r - osc_r, SET_C);
        chk(win_t > frck_r && fm_r > win_t, "R3 window before meter", fm_r - win_t, 1);
        chk(fm_f < frck_f && frck_f > t0, "R6 meter off before clk", frck_f - fm_f, 1);
        chk(done_t < osc_f, "R6 osc off after done", osc_f - done_t, 1);
    endtask

    task automatic t_codes;
        run(26, 17, 0, 113, 1);
        chk(code == 3'd4, "R7 count113", code, 4);
        run(26, 17, 0, 181, 1);
        chk(code == 3'd3, "R7 round up q2500", code, 3);
        run(26, 17, 0, 182, 1);
        chk(code == 3'd2, "R7 round down q2486", code, 2);
        run(26, 17, 0, 50, 1);
        chk(code == 3'd1, "R9 computed 9 -> 1", code, 1);
        run(26, 17, 0, 452608, 1);
        chk(code == 3'd0, "R7 quotient 1", code, 0);
    endtask

    task automatic t_refcoef;
        run(20, 10, 0, 100, 2);
        chk(code == 3'(exp_code(20, 10, 100)), "R12 ref20 coef10", code, exp_code(20, 10, 100));
    endtask

    task automatic t_late_valid;
        run(26, 17, 0, 113, 2 * POLL_I + 3);
        chk(fm_hi - h0 >= 2 * POLL_I && fm_hi - h0 <= 3 * POLL_I + 2, "R4 late valid window",
            fm_hi - h0, 3 * POLL_I + 1);
        chk(code == 3'd4, "R4 captured count", code, 4);
    endtask

    task automatic t_timeout;
        run(26, 17, 0, 150, -1);
        chk(fm_hi - h0 >= POLL_T * POLL_I && fm_hi - h0 <= POLL_T * POLL_I + 2, "R5 timeout length",
            fm_hi - h0, POLL_T * POLL_I + 1);
        chk(code == 3'd3, "R5 uses present count", code, 3);
        run(26, 17, 0, 113, -1);
        chk(code == 3'd4, "R5 count113 after timeout", code, 4);
    endtask

    task automatic t_zero;
        run(26, 17, 0, 0, 1);
        chk(code == 3'd3, "R8 zero count", code, 3);
    endtask

    task automatic t_override;
        run(26, 17, 5, 113, 1);
        chk(code == 3'd5, "R2 forced 5", code, 5);
        chk(osc_r < t0 && frck_r < t0 && fm_r < t0, "R2 no enables", osc_r, t0);
        chk(done_tot - d0 == 1, "R2 one done", done_tot - d0, 1);
        run(26, 17, 8, 113, 1);
        chk(code == 3'd0, "R9 forced 8 -> 0", code, 0);
    endtask

    task automatic t_busy;
        ref_mhz = 8'd26; coef = 8'd17; force_code = 8'd0; fm_count = 24'd113; vdelay = 1;
        t0 = t; d0 = done_tot;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (10) @(negedge clk);
        force_code = 8'd6; start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (done_tot > d0 && !osc_en) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
        force_code = 8'd0;
        chk(code == 3'd4, "R11 busy start ignored code", code, 4);
        chk(done_tot - d0 == 1, "R11 busy start no extra done", done_tot - d0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_codes();
        t_refcoef();
        t_late_valid();
        t_timeout();
        t_zero();
        t_override();
        t_busy();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #3000000;
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", t, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule